// File: doc/BRIEF.md
# Multi-Timer Prescaler Clock Tree

This block turns one system clock into five streams of single-cycle count-enable ticks, one for each timer channel of a timer array. No derived clocks are produced: every output is an enable in the system clock domain, high for exactly one cycle whenever the source chosen for that channel completes a period.

Two 8-bit prescalers form the first stage. The first feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. Each channel then has a power-of-two divider and a source mux, both controlled by one 4-bit field. That field can select the divided prescaler output or one of two external timer clock inputs. The external inputs are synchronised to the system clock, and each of their rising edges counts as one source event. Software configures the block through two write ports: one takes the word holding both prescaler values, and the other takes the word holding all five channel fields.

Top module: `prescale_clock_tree`

## Requirements
- R1: After reset both prescalers divide by 1, every channel field is 0 (divide by 2) and all counters are clear. Every tick output is low while reset is held. From the first cycle after reset, each channel ticks on every second cycle, starting in the second cycle.
- R2: A prescaler divides the system clock by its programmed value plus one, giving ratios from 1 to 256. Prescaler 0 takes bits [7:0] of the prescaler word and prescaler 1 takes bits [15:8].
- R3: Channels 0 and 1 count prescaler 0 events. Channels 2, 3 and 4 count prescaler 1 events.
- R4: Channel n is controlled by bits [4n+3:4n] of the select word. Codes 0, 1, 2 and 3 divide the prescaler events by 2, 4, 8 and 16. A channel in divided mode therefore ticks once every (prescale+1)*2^(code+1) cycles.
- R5: Codes 4 to 15 select the channel's external input. External input 0 drives channels 0 and 1, and external input 1 drives channels 2 to 4. A pulse on the other external input produces no tick.
- R6: An external input passes through a two-flop synchroniser. Its tick is high for exactly one cycle, in the cycle after the second clock edge that samples the input high.
- R7: A new prescaler value or divider code takes effect only at the next terminal count of that stage. A count already running completes at the old ratio.
- R8: A divided-mode tick never lasts longer than one cycle. Cycle by cycle, every output matches a model of R1 to R7 under any mix of configuration writes and external activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_wr | input | 1 | Write strobe for the prescaler word |
| pre_wdata | input | 16 | Prescaler word: prescaler 0 in [7:0], prescaler 1 in [15:8] |
| sel_wr | input | 1 | Write strobe for the channel select word |
| sel_wdata | input | 20 | Channel fields, 4 bits per channel |
| ext_clk_in | input | 2 | External timer clock inputs, asynchronous |
| tick_o | output | 5 | Per-channel single-cycle count enables |

## Verification
Fixed configurations measure each channel's tick period over whole periods. These runs separate the prescaler-to-channel grouping and the four divider codes from each other. Directed external pulses show that each external input reaches only its own channel group, and that any code of 4 or above selects it. A single rising edge pins the synchroniser latency to an exact cycle. A rewrite timed right after a terminal count shows that the running count is finished at the old ratio. A long stretch of random writes and random external toggling is then compared cycle by cycle with a bench model, which exposes errors in reload timing or mode switching.

// File: rtl/prescale_tree_pkg.sv
package prescale_tree_pkg;

    localparam int TREE_CHANNELS  = 5;
    localparam int TREE_PRESCALERS = 2;
    localparam int TREE_EXT_INPUTS = 2;
    localparam int TREE_PRE_W     = 8;
    localparam int TREE_FIELD_W   = 4;
    localparam int TREE_DIV_W     = 4;
    localparam int TREE_SPLIT_CH  = 2;   // first channel served by group 1

    typedef struct packed {
        logic                  use_ext;
        logic [TREE_DIV_W-1:0] limit;    // divide ratio minus one
    } chan_cfg_t;

    // Group (prescaler and external input) serving a channel
    function automatic int chan_group(input int ch);
        return (ch < TREE_SPLIT_CH) ? 0 : 1;
    endfunction

    // Field decode: 0..3 -> divide by 2,4,8,16 ; anything else -> external
    function automatic chan_cfg_t decode_field(input logic [TREE_FIELD_W-1:0] f);
        chan_cfg_t         r;
        logic [TREE_DIV_W:0] span;
        span = (TREE_DIV_W+1)'(2) << f[1:0];
        if (f[TREE_FIELD_W-1:2] == '0) begin
            r.use_ext = 1'b0;
            r.limit   = TREE_DIV_W'(span - 1'b1);
        end else begin
            r.use_ext = 1'b1;
            r.limit   = TREE_DIV_W'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pre_stage.sv
module pre_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ratio_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] act_q;

    assign tick_o = (cnt_q == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
            act_q <= ratio_i;          // new ratio only at terminal count
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= act_q);                                   // R2
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(act_q));                       // R7

endmodule

// File: rtl/ext_sync.sv
module ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rise_o
);
    logic s0_q, s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_q <= 1'b0;
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s0_q <= raw_i;
            s1_q <= s0_q;
            s2_q <= s1_q;
        end
    end

    assign rise_o = s1_q & ~s2_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);                               // R6

endmodule

// File: rtl/chan_div.sv
module chan_div
    import prescale_tree_pkg::*;
#(
    parameter int FIELD_W = TREE_FIELD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               pre_tick_i,
    input  logic               ext_rise_i,
    output logic               tick_o
);
    chan_cfg_t             cur;
    logic [TREE_DIV_W-1:0] cnt_q;
    logic [TREE_DIV_W-1:0] lim_q;
    logic                  div_tick;

    assign cur      = decode_field(TREE_FIELD_W'(field_i));
    assign div_tick = !cur.use_ext && pre_tick_i && (cnt_q == lim_q);
    assign tick_o   = cur.use_ext ? ext_rise_i : div_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= TREE_DIV_W'(1);
        end else if (cur.use_ext) begin
            cnt_q <= '0;
            lim_q <= cur.limit;
        end else if (pre_tick_i) begin
            if (cnt_q == lim_q) begin
                cnt_q <= '0;
                lim_q <= cur.limit;    // new ratio only at terminal count
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q);                                   // R4
    AST_DIV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_tick |=> !div_tick);                           // R8

endmodule

// File: rtl/prescale_clock_tree.sv
module prescale_clock_tree
    import prescale_tree_pkg::*;
#(
    parameter int NUM_CH  = TREE_CHANNELS,
    parameter int NUM_PRE = TREE_PRESCALERS,
    parameter int NUM_EXT = TREE_EXT_INPUTS,
    parameter int PRE_W   = TREE_PRE_W,
    parameter int FIELD_W = TREE_FIELD_W,
    localparam int PRE_WORD_W = NUM_PRE * PRE_W,
    localparam int SEL_WORD_W = NUM_CH * FIELD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pre_wr,
    input  logic [PRE_WORD_W-1:0] pre_wdata,
    input  logic                  sel_wr,
    input  logic [SEL_WORD_W-1:0] sel_wdata,
    input  logic [NUM_EXT-1:0]    ext_clk_in,
    output logic [NUM_CH-1:0]     tick_o
);
    logic [PRE_WORD_W-1:0] pre_q;
    logic [SEL_WORD_W-1:0] sel_q;
    logic [NUM_PRE-1:0]    pre_tick;
    logic [NUM_EXT-1:0]    ext_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            sel_q <= '0;
        end else begin
            if (pre_wr) pre_q <= pre_wdata;
            if (sel_wr) sel_q <= sel_wdata;
        end
    end

    for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
        pre_stage #(.W(PRE_W)) u_pre (
            .clk     (clk),
            .rst     (rst),
            .ratio_i (pre_q[g*PRE_W +: PRE_W]),
            .tick_o  (pre_tick[g])
        );
    end

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        ext_sync u_sync (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (ext_clk_in[e]),
            .rise_o (ext_rise[e])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = chan_group(c);
        chan_div #(.FIELD_W(FIELD_W)) u_div (
            .clk        (clk),
            .rst        (rst),
            .field_i    (sel_q[c*FIELD_W +: FIELD_W]),
            .pre_tick_i (pre_tick[GRP]),
            .ext_rise_i (ext_rise[GRP]),
            .tick_o     (tick_o[c])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (tick_o == '0) || rst);                    // R1

endmodule

// File: tb/prescale_clock_tree_test.sv
module prescale_clock_tree_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        pre_wr;
    logic [15:0] pre_wdata;
    logic        sel_wr;
    logic [19:0] sel_wdata;
    logic [1:0]  ext_clk_in;
    logic [4:0]  tick_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    int tick_acc [5];

    always #4 clk = ~clk;   // 125 MHz

    prescale_clock_tree uut (
        .clk(clk), .rst(rst), .pre_wr(pre_wr), .pre_wdata(pre_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .ext_clk_in(ext_clk_in),
        .tick_o(tick_o)
    );

    // ---------------- reference model of the requirements ----------------
    logic [15:0] m_pre;
    logic [19:0] m_sel;
    int   m_pcnt [2];
    int   m_pact [2];
    int   m_dcnt [5];
    int   m_dlim [5];
    logic m_s0 [2];
    logic m_s1 [2];
    logic m_s2 [2];

    function automatic int grp(input int ch);
        return (ch < 2) ? 0 : 1;
    endfunction

    function automatic logic m_exp(input int ch);
        int g;
        int code;
        g    = grp(ch);
        code = int'(m_sel[4*ch +: 4]);
        if (code >= 4) return m_s1[g] & ~m_s2[g];
        return (m_pcnt[g] == m_pact[g]) && (m_dcnt[ch] == m_dlim[ch]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre = '0;
            m_sel = '0;
            for (int g = 0; g < 2; g++) begin
                m_pcnt[g] = 0; m_pact[g] = 0;
                m_s0[g] = 1'b0; m_s1[g] = 1'b0; m_s2[g] = 1'b0;
            end
            for (int c = 0; c < 5; c++) begin
                m_dcnt[c] = 0; m_dlim[c] = 1;
            end
        end else begin
            bit pt [2];
            for (int g = 0; g < 2; g++) pt[g] = (m_pcnt[g] == m_pact[g]);
            for (int c = 0; c < 5; c++) begin
                int code;
                code = int'(m_sel[4*c +: 4]);
                if (code >= 4) begin
                    m_dcnt[c] = 0; m_dlim[c] = 1;
                end else if (pt[grp(c)]) begin
                    if (m_dcnt[c] == m_dlim[c]) begin
                        m_dcnt[c] = 0;
                        m_dlim[c] = (2 << code) - 1;
                    end else begin
                        m_dcnt[c]++;
                    end
                end
            end
            for (int g = 0; g < 2; g++) begin
                if (pt[g]) begin
                    m_pcnt[g] = 0;
                    m_pact[g] = int'(m_pre[8*g +: 8]);
                end else begin
                    m_pcnt[g]++;
                end
                m_s2[g] = m_s1[g];
                m_s1[g] = m_s0[g];
                m_s0[g] = ext_clk_in[g];
            end
            if (pre_wr) m_pre = pre_wdata;
            if (sel_wr) m_sel = sel_wdata;
        end
    end

    // ---------------- per-cycle observation ----------------
    always @(negedge clk) begin
        cycles++;
        for (int c = 0; c < 5; c++) if (tick_o[c]) tick_acc[c]++;
        if (model_on && !rst) begin
            checks++;
            for (int c = 0; c < 5; c++) begin
                if (tick_o[c] !== m_exp(c)) begin
                    errors++;
                    $display("FAIL R8/R7 ch%0d cycle %0d: tick actual %b expected %b",
                             c, cycles, tick_o[c], m_exp(c));
                end
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wr_pre(input logic [15:0] v);
        @(negedge clk); pre_wr = 1'b1; pre_wdata = v;
        @(negedge clk); pre_wr = 1'b0;
    endtask

    task automatic wr_sel(input logic [19:0] v);
        @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic window(input int ch, input int n, output int got);
        int start;
        @(negedge clk);
        start = tick_acc[ch];
        repeat (n) @(negedge clk);
        got = tick_acc[ch] - start;
    endtask

    initial begin
        int got;
        int gap;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 5; c++) tick_acc[c] = 0;
        rst = 1'b1; pre_wr = 1'b0; sel_wr = 1'b0;
        pre_wdata = '0; sel_wdata = '0; ext_clk_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ticks low in reset", int'(tick_o), 0);
        rst = 1'b0;
        model_on = 1'b1;

        // R1: first cycle quiet, then every second cycle
        check("R1 first cycle after reset", int'(tick_o), 0);
        for (int c = 0; c < 5; c++) begin
            window(c, 20, got);
            check($sformatf("R1 ch%0d reset rate", c), got, 10);
        end

        // R2 R3 R4: fixed ratios, ch4 on idle external input
        wr_pre({8'd4, 8'd2});
        wr_sel({4'd4, 4'd2, 4'd0, 4'd3, 4'd1});
        repeat (300) @(negedge clk);
        window(0, 120, got); check("R2/R4 ch0 pre3 div4", got, 10);
        window(1, 480, got); check("R3/R4 ch1 pre3 div16", got, 10);
        window(2, 100, got); check("R2/R3 ch2 pre5 div2", got, 10);
        window(3, 400, got); check("R4 ch3 pre5 div8", got, 10);
        window(4, 100, got); check("R5 ch4 idle external", got, 0);

        // R5: ext1 reaches ch4 (code 9), not ch0 (code 4 on ext0)
        wr_sel({4'd9, 4'd2, 4'd0, 4'd3, 4'd4});
        repeat (5) @(negedge clk);
        begin
            int s0, s4;
            s0 = tick_acc[0]; s4 = tick_acc[4];
            for (int k = 0; k < 5; k++) begin
                ext_clk_in[1] = 1'b1; repeat (3) @(negedge clk);
                ext_clk_in[1] = 1'b0; repeat (3) @(negedge clk);
            end
            repeat (4) @(negedge clk);
            check("R5 ch4 ext1 edges", tick_acc[4] - s4, 5);
            check("R5 ch0 ignores ext1", tick_acc[0] - s0, 0);
        end

        // R6: exact synchroniser latency on ch0
        ext_clk_in[0] = 1'b1;
        @(negedge clk); check("R6 one edge after input", int'(tick_o[0]), 0);
        @(negedge clk); check("R6 two edges after input", int'(tick_o[0]), 1);
        @(negedge clk); check("R6 pulse width", int'(tick_o[0]), 0);
        ext_clk_in[0] = 1'b0;
        repeat (4) @(negedge clk);

        // R7: ch0 div2 on prescale 10, rewrite to 0 right after a tick
        wr_pre({8'd4, 8'd9});
        wr_sel({4'd9, 4'd2, 4'd0, 4'd3, 4'd0});
        repeat (60) @(negedge clk);
        while (!tick_o[0]) @(negedge clk);
        pre_wr = 1'b1; pre_wdata = {8'd4, 8'd0};
        gap = 0;
        do begin
            @(negedge clk);
            pre_wr = 1'b0;
            gap++;
        end while (!tick_o[0] && gap < 100);
        check("R7 running count completes", gap, 11);

        // R8: random writes and external activity against the model
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            pre_wr = ($urandom_range(0, 31) == 0);
            pre_wdata = {4'd0, 4'($urandom_range(0, 15)), 4'd0, 4'($urandom_range(0, 15))};
            if ($urandom_range(0, 7) == 0) pre_wdata = 16'($urandom);
            sel_wr = ($urandom_range(0, 31) == 0);
            sel_wdata = 20'($urandom);
            if ($urandom_range(0, 5) == 0) ext_clk_in[0] = ~ext_clk_in[0];
            if ($urandom_range(0, 5) == 0) ext_clk_in[1] = ~ext_clk_in[1];
        end
        @(negedge clk);
        pre_wr = 1'b0; sel_wr = 1'b0;
        repeat (20) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule